// File: doc/BRIEF.md
# Serial Flash Fast-Read Responder

This block is the device-side serial engine for a flash part's high-speed read commands. A host selects the device by pulling chip select low. It clocks in an 8-bit opcode and a 24-bit start address, most significant bit first, and then eight dummy clocks. The device then streams bytes from a small on-chip byte array. In single mode the bytes go out on one output line. In dual mode they go out two bits per clock on both data lines. The byte address steps forward after every byte, so a read can begin anywhere and run for as long as chip select stays low.

Serial clock, chip select and serial input are oversampled by the fabric clock through a synchronizer stage. Shifting happens on the detected clock edges, and all outputs and output enables are registered. A separate load port fills the byte array; the serial side only reads it.

Top module: `spi_fast_read_resp`

## Requirements
- R1: After reset, both output enables are low and both data outputs are 0. A data output is also 0 whenever its enable is low.
- R2: Opcode 0x0B selects single mode. Each byte leaves on io1 most significant bit first, one bit per serial clock, and io0_oe stays low.
- R3: Opcode 0x3B selects dual mode. Each byte takes four serial clocks: io1 carries bits 7, 5, 3, 1 and io0 carries bits 6, 4, 2, 0, in that order. Both enables are high.
- R4: Both enables stay low through the opcode, the 24 address bits and the 8 dummy clocks. The first data bit is driven after the falling edge of the eighth dummy clock.
- R5: The address arrives most significant bit first. The first byte comes from that address, and each later byte comes from the next higher address.
- R6: The address counter is 21 bits wide and steps from 0x1FFFFF to 0x000000 without stopping. The array location used is the low MEM_AW bits of the address.
- R7: Raising chip select at any point, including in the middle of a byte, drops both enables. The next selection starts again with a fresh opcode.
- R8: An opcode other than 0x0B or 0x3B leaves both enables low for the rest of that selection. A valid command after reselection works normally.
- R9: Inputs are taken on serial clock rising edges. The data outputs change only after a falling edge, so they hold their value across a rising edge.
- R10: A write on the load port stores load_data at load_addr. A later read of that location returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, idle low |
| io0_in | input | 1 | Serial input for opcode, address and dummy bits |
| io0_out | output | 1 | Even data bits in dual mode |
| io0_oe | output | 1 | Drive enable for io0 |
| io1_out | output | 1 | Single-mode data, or odd bits in dual mode |
| io1_oe | output | 1 | Drive enable for io1 |
| load_we | input | 1 | Byte array write strobe |
| load_addr | input | MEM_AW | Byte array write location |
| load_data | input | 8 | Byte array write data |

## Verification
The assertions assume that chip select and the serial input change only while the serial clock is low. They also assume that each serial clock level lasts several fabric clocks longer than the synchronizer delay, so that every edge is seen once and the bits line up with it. They further assume that chip select stays high while the array is being loaded. The directed host tasks hold each serial clock level for eight fabric clocks, change the input and chip select only in the low phase, and load the array before any selection.

// File: rtl/spi_fr_pkg.sv
package spi_fr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_IGNORE
  } fr_state_t;

  localparam logic [7:0] OP_READ_X1 = 8'h0B;
  localparam logic [7:0] OP_READ_X2 = 8'h3B;
endpackage

// File: rtl/spi_fr_sync.sv
module spi_fr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic si,
  output logic cs_hi,
  output logic rise,
  output logic fall,
  output logic si_s
);
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] si_q;
  logic              sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= '1;
      sck_q <= '0;
      si_q  <= '0;
      sck_d <= 1'b0;
    end else begin
      cs_q  <= {cs_q[STAGES-2:0], cs_n};
      sck_q <= {sck_q[STAGES-2:0], sclk};
      si_q  <= {si_q[STAGES-2:0], si};
      sck_d <= sck_q[STAGES-1];
    end
  end

  assign cs_hi = cs_q[STAGES-1];
  assign si_s  = si_q[STAGES-1];
  assign rise  = sck_q[STAGES-1] & ~sck_d;
  assign fall  = ~sck_q[STAGES-1] & sck_d;
endmodule

// File: rtl/spi_fr_store.sv
module spi_fr_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_fr_engine.sv
module spi_fr_engine
  import spi_fr_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int SPAN_W     = 21,
  parameter int MEM_AW     = 8,
  parameter int DUMMY_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_hi,
  input  logic              rise,
  input  logic              fall,
  input  logic              si,
  input  logic [7:0]        rdata,
  output logic [MEM_AW-1:0] raddr,
  output logic              io0_out,
  output logic              io0_oe,
  output logic              io1_out,
  output logic              io1_oe,
  output fr_state_t         state,
  output logic [SPAN_W-1:0] addr
);
  localparam int CNT_W = $clog2(ADDR_W);

  logic [CNT_W-1:0] cnt;
  logic [7:0]       op_sh;
  logic [7:0]       op_next;
  logic             dual;
  logic [7:0]       sh;
  logic [7:0]       src;
  logic [2:0]       phase;
  logic [2:0]       last_phase;

  assign op_next    = {op_sh[6:0], si};
  assign src        = (phase == 3'd0) ? rdata : sh;
  assign last_phase = dual ? 3'd3 : 3'd7;
  assign raddr      = addr[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      op_sh   <= '0;
      dual    <= 1'b0;
      addr    <= '0;
      sh      <= '0;
      phase   <= '0;
      io0_out <= 1'b0;
      io0_oe  <= 1'b0;
      io1_out <= 1'b0;
      io1_oe  <= 1'b0;
    end else if (cs_hi) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      phase   <= '0;
      io0_out <= 1'b0;
      io0_oe  <= 1'b0;
      io1_out <= 1'b0;
      io1_oe  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_CMD;
          cnt   <= '0;
        end
        ST_CMD: if (rise) begin
          op_sh <= op_next;
          if (cnt == CNT_W'(7)) begin
            cnt <= '0;
            if (op_next == OP_READ_X1) begin
              dual  <= 1'b0;
              state <= ST_ADDR;
            end else if (op_next == OP_READ_X2) begin
              dual  <= 1'b1;
              state <= ST_ADDR;
            end else begin
              state <= ST_IGNORE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ADDR: if (rise) begin
          addr <= {addr[SPAN_W-2:0], si};
          if (cnt == CNT_W'(ADDR_W - 1)) begin
            cnt   <= '0;
            state <= ST_DUMMY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DUMMY: if (rise) begin
          if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
            cnt   <= '0;
            phase <= '0;
            state <= ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: if (fall) begin
          if (phase == 3'd0) addr <= addr + 1'b1;
          io1_out <= src[7];
          io1_oe  <= 1'b1;
          if (dual) begin
            io0_out <= src[6];
            io0_oe  <= 1'b1;
            sh      <= {src[5:0], 2'b00};
          end else begin
            sh <= {src[6:0], 1'b0};
          end
          phase <= (phase == last_phase) ? 3'd0 : phase + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_fast_read_resp.sv
module spi_fast_read_resp
  import spi_fr_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SPAN_W      = 21,
  parameter int MEM_AW      = 8,
  parameter int DUMMY_CLKS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              io0_in,
  output logic              io0_out,
  output logic              io0_oe,
  output logic              io1_out,
  output logic              io1_oe,
  input  logic              load_we,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [7:0]        load_data
);
  logic              cs_hi;
  logic              rise;
  logic              fall;
  logic              si_s;
  logic [7:0]        rdata;
  logic [MEM_AW-1:0] raddr;
  fr_state_t         state;
  logic [SPAN_W-1:0] addr;

  spi_fr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .cs_n (cs_n),
    .sclk (sclk),
    .si   (io0_in),
    .cs_hi(cs_hi),
    .rise (rise),
    .fall (fall),
    .si_s (si_s)
  );

  spi_fr_store #(.AW(MEM_AW), .DW(8)) u_store (
    .clk  (clk),
    .we   (load_we),
    .waddr(load_addr),
    .wdata(load_data),
    .raddr(raddr),
    .rdata(rdata)
  );

  spi_fr_engine #(
    .ADDR_W    (ADDR_W),
    .SPAN_W    (SPAN_W),
    .MEM_AW    (MEM_AW),
    .DUMMY_CLKS(DUMMY_CLKS)
  ) u_engine (
    .clk    (clk),
    .rst    (rst),
    .cs_hi  (cs_hi),
    .rise   (rise),
    .fall   (fall),
    .si     (si_s),
    .rdata  (rdata),
    .raddr  (raddr),
    .io0_out(io0_out),
    .io0_oe (io0_oe),
    .io1_out(io1_out),
    .io1_oe (io1_oe),
    .state  (state),
    .addr   (addr)
  );
endmodule

// File: rtl/spi_fast_read_resp_chk.sv
module spi_fast_read_resp_chk
  import spi_fr_pkg::*;
#(
  parameter int SPAN_W = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              io0_out,
  input logic              io0_oe,
  input logic              io1_out,
  input logic              io1_oe,
  input logic              cs_hi,
  input logic              fall,
  input fr_state_t         state,
  input logic [SPAN_W-1:0] addr
);
  assert_quiet_io1_R1: assert property (@(posedge clk) disable iff (rst)
    !io1_oe |-> !io1_out);

  assert_quiet_io0_R1: assert property (@(posedge clk) disable iff (rst)
    !io0_oe |-> !io0_out);

  assert_pair_enable_R3: assert property (@(posedge clk) disable iff (rst)
    io0_oe |-> io1_oe);

  assert_no_drive_early_R4: assert property (@(posedge clk) disable iff (rst)
    (state != ST_DATA) |-> (!io1_oe && !io0_oe));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && $past(state) == ST_DATA && !$stable(addr))
      |-> (addr == SPAN_W'($past(addr) + 1'b1)));

  assert_deselect_R7: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (!io1_oe && !io0_oe));

  assert_fall_only_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(fall) && !$past(cs_hi)) |-> ($stable(io1_out) && $stable(io0_out)));
endmodule

bind spi_fast_read_resp spi_fast_read_resp_chk #(.SPAN_W(SPAN_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .io0_out(io0_out),
  .io0_oe (io0_oe),
  .io1_out(io1_out),
  .io1_oe (io1_oe),
  .cs_hi  (cs_hi),
  .fall   (fall),
  .state  (state),
  .addr   (addr)
);

// File: tb/tb_spi_fast_read_resp.sv
module tb_spi_fast_read_resp;
  localparam int MEM_AW = 8;
  localparam int HALF   = 8;
  localparam int DEPTH  = 1 << MEM_AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cs_n = 1'b1;
  logic              sclk = 1'b0;
  logic              io0_in = 1'b0;
  logic              io0_out, io0_oe, io1_out, io1_oe;
  logic              load_we = 1'b0;
  logic [MEM_AW-1:0] load_addr = '0;
  logic [7:0]        load_data = '0;

  logic [7:0] model [DEPTH];
  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  spi_fast_read_resp dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .io0_in(io0_in),
    .io0_out(io0_out), .io0_oe(io0_oe), .io1_out(io1_out), .io1_oe(io1_oe),
    .load_we(load_we), .load_addr(load_addr), .load_data(load_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_byte(input logic [MEM_AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    load_we = 1'b1; load_addr = a; load_data = d;
    @(negedge clk);
    load_we = 1'b0;
    model[a] = d;
  endtask

  task automatic pulse(input logic b);
    io0_in = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  // opcode, 24-bit address, dummy clocks; checks enables stay low (R4)
  task automatic preamble(input logic [7:0] op, input logic [23:0] a, output bit quiet);
    quiet = 1'b1;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 7; i >= 0; i--) begin
      pulse(op[i]); wait_clk(3);
      if (io1_oe || io0_oe) quiet = 1'b0;
    end
    for (int i = 23; i >= 0; i--) begin
      pulse(a[i]); wait_clk(3);
      if (io1_oe || io0_oe) quiet = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      if (i != 0) begin
        wait_clk(3);
        if (io1_oe || io0_oe) quiet = 1'b0;
      end
      pulse(1'b0);
    end
  endtask

  task automatic deselect();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  // reads nbytes after the preamble; first sample follows the last dummy fall
  task automatic stream(input bit dual, input logic [23:0] a, input int nbytes, input string req);
    int bpc = dual ? 4 : 8;
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] got = '0;
      logic [7:0] exp = model[MEM_AW'(a + 24'(k))];
      bit oe_ok = 1'b1;
      for (int c = 0; c < bpc; c++) begin
        if (k != 0 || c != 0) pulse(1'b0);
        wait_clk(HALF);
        if (!io1_oe || (io0_oe != dual)) oe_ok = 1'b0;
        if (dual) got = {got[5:0], io1_out, io0_out};
        else      got = {got[6:0], io1_out};
      end
      chk(got == exp, req, 32'(got), 32'(exp));
      chk(oe_ok, {req, " enables"}, 32'({io1_oe, io0_oe}), 32'({1'b1, dual}));
    end
  endtask

  task automatic test_reset_R1();
    chk(!io1_oe && !io0_oe, "R1 enables after reset", 32'({io1_oe, io0_oe}), 0);
    chk(!io1_out && !io0_out, "R1 outputs after reset", 32'({io1_out, io0_out}), 0);
  endtask

  task automatic test_single_R2();
    bit q;
    preamble(8'h0B, 24'h000010, q);
    chk(q, "R4 quiet before data (single)", 32'(q), 1);
    stream(1'b0, 24'h000010, 5, "R2/R5 single stream");
    deselect();
  endtask

  task automatic test_dual_R3();
    bit q;
    preamble(8'h3B, 24'h1A2B37, q);
    chk(q, "R4 quiet before data (dual)", 32'(q), 1);
    stream(1'b1, 24'h1A2B37, 4, "R3/R5 dual stream");
    deselect();
  endtask

  task automatic test_wrap_R6();
    bit q;
    preamble(8'h0B, 24'h1FFFFE, q);
    stream(1'b0, 24'h1FFFFE, 4, "R6 wrap single");
    deselect();
    preamble(8'h3B, 24'h1FFFFF, q);
    stream(1'b1, 24'h1FFFFF, 3, "R6 wrap dual");
    deselect();
  endtask

  task automatic test_abort_R7();
    bit q;
    preamble(8'h0B, 24'h000020, q);
    wait_clk(HALF);
    pulse(1'b0); pulse(1'b0);
    cs_n = 1'b1;
    wait_clk(HALF);
    chk(!io1_oe && !io0_oe, "R7 enables after mid-byte deselect", 32'({io1_oe, io0_oe}), 0);
    wait_clk(HALF);
    preamble(8'h3B, 24'h000030, q);
    stream(1'b1, 24'h000030, 2, "R7 fresh command after abort");
    deselect();
  endtask

  task automatic test_bad_op_R8();
    bit q;
    bit quiet = 1'b1;
    preamble(8'h03, 24'h000040, q);
    for (int i = 0; i < 16; i++) begin
      pulse(1'b1); wait_clk(HALF);
      if (io1_oe || io0_oe) quiet = 1'b0;
    end
    chk(q && quiet, "R8 unknown opcode ignored", 32'({q, quiet}), 32'h3);
    deselect();
    preamble(8'h0B, 24'h000041, q);
    stream(1'b0, 24'h000041, 2, "R8 valid command afterwards");
    deselect();
  endtask

  task automatic test_hold_R9();
    bit q;
    logic b0;
    logic [7:0] e = model[8'h50];
    preamble(8'h0B, 24'h000050, q);
    wait_clk(HALF);
    b0 = io1_out;
    chk(b0 == e[7], "R9 first bit", 32'(b0), 32'(e[7]));
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    chk(io1_out == b0, "R9 held across rising edge", 32'(io1_out), 32'(b0));
    sclk = 1'b0;
    wait_clk(HALF);
    chk(io1_out == e[6], "R9 next bit after falling edge", 32'(io1_out), 32'(e[6]));
    deselect();
  endtask

  task automatic test_load_R10();
    bit q;
    load_byte(8'h44, 8'hC3);
    preamble(8'h0B, 24'h000044, q);
    stream(1'b0, 24'h000044, 1, "R10 reloaded byte");
    deselect();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    test_reset_R1();
    for (int i = 0; i < DEPTH; i++) load_byte(MEM_AW'(i), 8'((i * 37 + 11) ^ 8'h5A));
    wait_clk(4);
    test_single_R2();
    test_dual_R3();
    test_wrap_R6();
    test_abort_R7();
    test_bad_op_R8();
    test_hold_R9();
    test_load_R10();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule